// File: doc/BRIEF.md
# Transmit byte queue with threshold interrupt events

This block is the byte queue that sits between a transmit data register and a serial transmitter. Each write strobe offers one byte. The transmitter takes bytes at its own pace through a valid/ready handshake. The queue keeps an exact fill count and reports full and empty. It also raises one-cycle events that an interrupt register can use to set or clear its watermark and empty bits.

The watermark threshold is picked by a 2-bit select. The watermark set event fires when an accepted write leaves the fill count at or above the threshold. The clear event fires when an accepted pop leaves the count below it. Draining the queue to zero raises the empty event and also withdraws the watermark. A write that finds the queue full is dropped without any indication. A flush input empties the queue at once.

Top module: `txq_watermark_fifo`

## Requirements
- R1: After synchronous reset, level is 0, empty is 1, full is 0, rd_valid is 0, and wm_set, wm_clr and empty_set are 0.
- R2: Bytes leave on rd_data in the order they were written. rd_valid is 1 exactly when level is non-zero. A pop happens on a cycle with rd_valid and rd_ready both 1.
- R3: Capacity is DEPTH (default 32), so level runs from 0 to 32. full is 1 exactly when level equals 32. A write while full is discarded, does not change level, and raises no wm_set.
- R4: empty is 1 exactly when level is 0, and it drops in the cycle after the first accepted write.
- R5: wm_sel encodes the threshold as 0 -> 1, 1 -> 4, 2 -> 8, 3 -> 16 (DEPTH>>(4-sel) for sel>0). wm_set pulses for one cycle, in the cycle after an accepted write, when the resulting level is at or above the threshold.
- R6: wm_clr pulses for one cycle, in the cycle after an accepted pop, when the resulting level is below the threshold.
- R7: empty_set pulses for one cycle in the cycle after a pop leaves level at 0.
- R8: An accepted write and pop in the same cycle leave level unchanged. The events are judged on that level, and byte order is kept.
- R9: flush sets level to 0 on the next edge and overrides any write or pop in the same cycle. If level was non-zero, empty_set and wm_clr pulse; otherwise neither does.
- R10: A pop request while empty is ignored: level stays 0 and no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to enqueue |
| flush | input | 1 | Soft reset of the queue contents |
| wm_sel | input | 2 | Watermark threshold select |
| rd_ready | input | 1 | Transmitter takes the head byte |
| rd_valid | output | 1 | Head byte is present |
| rd_data | output | 8 | Head byte |
| level | output | 6 | Number of stored bytes |
| full | output | 1 | Level equals capacity |
| empty | output | 1 | Level is zero |
| wm_set | output | 1 | Watermark set event pulse |
| wm_clr | output | 1 | Watermark clear event pulse |
| empty_set | output | 1 | Empty interrupt event pulse |

## Verification
A corrupted fill count shows up on level and on the full/empty flags in the very next cycle, and it moves every later threshold event off its expected edge. A pointer fault does not change level. It shows up only when the damaged slot reaches the head, as a wrong byte on rd_data, after as many pops as there were entries ahead of it. The bench compares each output against an arithmetic queue model on every cycle, so either kind of fault is caught on the first cycle where it becomes visible.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef struct packed {
        logic push;   // accepted write
        logic pop;    // accepted read
        logic clear;  // flush, overrides push and pop
    } txq_op_t;

    // Threshold for a 2-bit select: 1, then DEPTH/8, DEPTH/4, DEPTH/2.
    function automatic int unsigned wm_threshold(input logic [1:0] sel,
                                                 input int unsigned depth);
        if (sel == 2'd0) return 1;
        return depth >> (4 - int'(sel));
    endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store
    import txq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  txq_op_t           op,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || op.clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (op.push) wr_ptr <= bump(wr_ptr);
            if (op.pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (op.push && !op.clear) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/txq_count.sv
module txq_count
    import txq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  txq_op_t          op,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] level_next,
    output logic             full,
    output logic             empty
);
    always_comb begin
        if (op.clear)
            level_next = '0;
        else
            level_next = level + LVL_W'(op.push) - LVL_W'(op.pop);
    end

    always_ff @(posedge clk) begin
        if (rst) level <= '0;
        else     level <= level_next;
    end

    assign full  = (level == LVL_W'(DEPTH));
    assign empty = (level == '0);
endmodule

// File: rtl/txq_events.sv
module txq_events
    import txq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  txq_op_t          op,
    input  logic [1:0]       wm_sel,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] level_next,
    output logic             wm_set,
    output logic             wm_clr,
    output logic             empty_set
);
    logic [LVL_W-1:0] thr;
    logic             was_busy;

    assign thr      = LVL_W'(wm_threshold(wm_sel, DEPTH));
    assign was_busy = (level != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wm_set    <= 1'b0;
            wm_clr    <= 1'b0;
            empty_set <= 1'b0;
        end else if (op.clear) begin
            wm_set    <= 1'b0;
            wm_clr    <= was_busy;
            empty_set <= was_busy;
        end else begin
            wm_set    <= op.push && (level_next >= thr);
            wm_clr    <= op.pop  && (level_next <  thr);
            empty_set <= op.pop  && (level_next == '0);
        end
    end
endmodule

// File: rtl/txq_watermark_fifo.sv
module txq_watermark_fifo
    import txq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flush,
    input  logic [1:0]        wm_sel,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              wm_set,
    output logic              wm_clr,
    output logic              empty_set
);
    txq_op_t          op;
    logic [LVL_W-1:0] level_next;

    assign op.push  = wr_en && !full;
    assign op.pop   = rd_ready && !empty;
    assign op.clear = flush;
    assign rd_valid = !empty;

    txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .op(op), .wr_data(wr_data), .rd_data(rd_data)
    );

    txq_count #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_count (
        .clk(clk), .rst(rst), .op(op), .level(level),
        .level_next(level_next), .full(full), .empty(empty)
    );

    txq_events #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_events (
        .clk(clk), .rst(rst), .op(op), .wm_sel(wm_sel), .level(level),
        .level_next(level_next), .wm_set(wm_set), .wm_clr(wm_clr),
        .empty_set(empty_set)
    );
endmodule

// File: rtl/txq_checker.sv
module txq_checker
    import txq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             flush,
    input logic             rd_ready,
    input logic [1:0]       wm_sel,
    input logic [LVL_W-1:0] level,
    input logic             empty,
    input logic             wm_set,
    input logic             wm_clr,
    input logic             empty_set
);
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_W'(DEPTH) && wr_en && !rd_ready && !flush)
        |=> (level == LVL_W'(DEPTH) && !wm_set));

    assert_wm_set_level_R5: assert property (@(posedge clk) disable iff (rst)
        (!flush && wr_en && level < LVL_W'(DEPTH))
        |=> (wm_set == (level >= LVL_W'(wm_threshold($past(wm_sel), DEPTH)))));

    assert_events_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(wm_set && wm_clr));

    assert_empty_event_R7: assert property (@(posedge clk) disable iff (rst)
        empty_set |-> (empty && wm_clr));

    assert_flush_zero_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0 && !wm_set));

    assert_pop_on_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && rd_ready && !wr_en && !flush)
        |=> (level == '0 && !wm_clr && !empty_set));
endmodule

bind txq_watermark_fifo txq_checker #(.DEPTH(DEPTH)) u_txq_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .flush(flush), .rd_ready(rd_ready),
    .wm_sel(wm_sel), .level(level), .empty(empty), .wm_set(wm_set),
    .wm_clr(wm_clr), .empty_set(empty_set)
);

// File: tb/tb_txq_watermark_fifo.sv
`timescale 1ns/1ps
module tb_txq_watermark_fifo;
    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flush = 1'b0;
    logic [1:0] wm_sel = '0;
    logic       rd_ready = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [5:0] level;
    logic       full, empty, wm_set, wm_clr, empty_set;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R2";

    // reference queue
    logic [7:0] mq [0:DEPTH];
    int mcount = 0;
    bit e_set, e_clr, e_es;

    always #5 clk = ~clk;

    txq_watermark_fifo dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
        .wm_sel(wm_sel), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .level(level), .full(full), .empty(empty),
        .wm_set(wm_set), .wm_clr(wm_clr), .empty_set(empty_set)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s) actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    function automatic int thr_of(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic compare();
        chk(level == 6'(mcount), "R3 level", level, mcount);
        chk(full == (mcount == DEPTH), "R3 full", full, mcount == DEPTH);
        chk(empty == (mcount == 0), "R4 empty", empty, mcount == 0);
        chk(rd_valid == (mcount != 0), "R2 valid", rd_valid, mcount != 0);
        if (mcount != 0) chk(rd_data == mq[0], "R2 data", rd_data, mq[0]);
        chk(wm_set == e_set, "R5 wm_set", wm_set, e_set);
        chk(wm_clr == e_clr, "R6 wm_clr", wm_clr, e_clr);
        chk(empty_set == e_es, "R7 empty_set", empty_set, e_es);
    endtask

    // drive at negedge, advance one edge, check at next negedge
    task automatic step(input bit wr, input logic [7:0] d, input bit rd, input bit fl);
        bit push, pop;
        int n, t;
        wr_en = wr; wr_data = d; rd_ready = rd; flush = fl;
        t = thr_of(int'(wm_sel));
        if (fl) begin
            e_set = 0; e_clr = (mcount != 0); e_es = (mcount != 0);
            mcount = 0;
        end else begin
            push = wr && (mcount < DEPTH);
            pop  = rd && (mcount > 0);
            if (pop) begin
                for (int i = 0; i < DEPTH; i++) mq[i] = mq[i+1];
                mcount--;
            end
            if (push) begin
                mq[mcount] = d;
                mcount++;
            end
            n = mcount;
            e_set = push && (n >= t);
            e_clr = pop && (n < t);
            e_es  = pop && (n == 0);
        end
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        phase = "R1";
        e_set = 0; e_clr = 0; e_es = 0;
        compare();

        // R3/R5/R6/R7/R10: fill past capacity and drain past empty, every threshold
        for (int s = 0; s < 4; s++) begin
            wm_sel = 2'(s);
            phase = "R3";
            for (int i = 0; i < DEPTH + 2; i++) step(1, 8'(s * 40 + i), 0, 0);
            phase = "R10";
            for (int i = 0; i < DEPTH + 3; i++) step(0, 8'h00, 1, 0);
        end

        // R8 simultaneous push and pop
        wm_sel = 2'd2;
        phase = "R8";
        for (int i = 0; i < 5; i++) step(1, 8'(100 + i), 0, 0);
        for (int i = 0; i < 10; i++) step(1, 8'(150 + i), 1, 0);
        for (int i = 0; i < 3; i++) step(1, 8'(170 + i), 0, 0);
        for (int i = 0; i < 5; i++) step(1, 8'(180 + i), 1, 0);
        for (int i = 0; i < 10; i++) step(0, 8'h00, 1, 0);

        // R9 flush with write and pop pending, then flush on empty
        phase = "R9";
        for (int i = 0; i < 6; i++) step(1, 8'(200 + i), 0, 0);
        step(1, 8'hEE, 1, 1);
        step(0, 8'h00, 0, 1);
        step(1, 8'h5A, 0, 0);
        step(0, 8'h00, 1, 0);

        // mixed traffic across all thresholds
        phase = "R2";
        for (int s = 0; s < 4; s++) begin
            wm_sel = 2'(s);
            for (int i = 0; i < 80; i++)
                step((i % 3) != 0, 8'(i * 7 + s), (i % 2) == 1 || i > 60, 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule